// File: doc/BRIEF.md
# NAND Hamming ECC Checker and Single-Bit Corrector

This block decides what to do with one 512-byte NAND data chunk after it has been read back. It takes two 24-bit Hamming codes: the one kept in the page's spare area, and the one just computed over the data that was read. It spreads each code over a 32-bit word in which the column parity and line parity sit in separate halves. It then XORs the two words and counts the set bits of the result. From that count it decides whether the chunk is clean, holds a single-bit data error it can fix, has a damaged stored code, or cannot be recovered. When the error is fixable it reports the byte offset and the bit index to flip.

A small correction path sits beside the classifier. The page buffer presents a byte and that byte's offset in the chunk. If the last result was a fixable error and the offset matches, the byte comes back with the faulty bit inverted. Every other byte passes through unchanged. A freshly erased chunk stores all-ones in its spare code while the data computes to all-zeros. That case is recognised and reported as clean. Generating the code over the data and storing the page are done elsewhere.

Top module: `nand_ecc_check`

## Requirements
- R1: While reset is held and after it is released, `res_valid` is 0, `res_status` is 0 (clean), and `res_byte` and `res_bit` are 0.
- R2: `in_valid` is sampled on a rising edge. `res_valid` goes high after the next rising edge and stays high for exactly one cycle. All result outputs update at that same edge.
- R3: A code is a 24-bit value whose byte k sits at bits 8k+7:8k. It is spread into a 32-bit word as follows: byte 0 goes to bits 7:0, byte 1 to bits 23:16, the upper nibble of byte 2 to bits 27:24 and the lower nibble of byte 2 to bits 11:8. All other bits are 0. The syndrome is the XOR of the spread stored code and the spread computed code. A zero syndrome gives status 0 (clean).
- R4: A syndrome with exactly 12 set bits gives status 1 (fixed). In that case `res_byte` equals syndrome bits 27:19 and `res_bit` equals syndrome bits 18:16.
- R5: A syndrome with exactly 1 set bit gives status 2 (stored code damaged). No byte is marked for change.
- R6: Any other nonzero count of set bits gives status 3 (uncorrectable).
- R7: If the stored code is 0xFFFFFF and the computed code is 0x000000, the chunk is treated as erased and gets status 0 (clean). The spread words are then 0x0FFF0FFF and 0.
- R8: `res_byte` and `res_bit` are 0 whenever `res_status` is not 1.
- R9: Status and location keep their values until the next result, whatever the code inputs do in between.
- R10: `dat_out` equals `dat_in` with bit `res_bit` inverted when `res_status` is 1 and `dat_addr` equals `res_byte`. In every other case `dat_out` equals `dat_in`. This path has no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: the two codes are presented this cycle |
| stored_ecc | input | 24 | Code read from the spare area |
| calc_ecc | input | 24 | Code computed over the data read back |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_status | output | 2 | 0 clean, 1 fixed, 2 stored code damaged, 3 uncorrectable |
| res_byte | output | 9 | Offset of the byte to fix |
| res_bit | output | 3 | Index of the bit to fix |
| dat_addr | input | 9 | Offset of the byte on `dat_in` |
| dat_in | input | 8 | Data byte from the page buffer |
| dat_out | output | 8 | Data byte after any fix |

## Verification
The codes are driven at a falling edge, so the edge that follows samples the strobe. The status and location are due after the second rising edge. The bench reads them at the falling edge after that one. It also confirms that `res_valid` is still low one falling edge earlier and low again one falling edge later. The correction output has no register, so the bench changes `dat_addr` and `dat_in` at a falling edge and reads `dat_out` a unit of time later, within the same cycle. The hold check changes the codes without a strobe and then watches the outputs over several further falling edges.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  localparam int CODE_W = 24;
  localparam int WORD_W = 32;
  localparam int BIT_W  = 3;
  localparam int FIXABLE_WEIGHT = 12;
  localparam logic [WORD_W-1:0] BLANK_SPREAD = 32'h0FFF_0FFF;

  typedef enum logic [1:0] {
    ST_CLEAN   = 2'd0,
    ST_FIXED   = 2'd1,
    ST_ECC_BAD = 2'd2,
    ST_UNCORR  = 2'd3
  } ecc_status_e;

  // Separate column parity (low half) from line parity (high half).
  function automatic logic [WORD_W-1:0] spread_code(input logic [CODE_W-1:0] c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[7:0]   = c[7:0];
    w[23:16] = c[15:8];
    w[27:24] = c[23:20];
    w[11:8]  = c[19:16];
    return w;
  endfunction

  function automatic int unsigned ones_in(input logic [WORD_W-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < WORD_W; i++) n += int'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/nand_ecc_syndrome.sv
module nand_ecc_syndrome
  import nand_ecc_pkg::*;
(
  input  logic [CODE_W-1:0] stored_ecc,
  input  logic [CODE_W-1:0] calc_ecc,
  output logic [WORD_W-1:0] syndrome,
  output logic              blank_hit
);
  logic [WORD_W-1:0] stored_w;
  logic [WORD_W-1:0] calc_w;

  always_comb begin
    stored_w  = spread_code(stored_ecc);
    calc_w    = spread_code(calc_ecc);
    syndrome  = stored_w ^ calc_w;
    blank_hit = (stored_w == BLANK_SPREAD) && (calc_w == '0);
  end
endmodule

// File: rtl/nand_ecc_popstage.sv
module nand_ecc_popstage #(
  parameter int WIDTH   = 32,
  parameter int GROUP_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic [WIDTH-1:0]            word,
  output logic [WIDTH/GROUP_W-1:0][$clog2(GROUP_W+1)-1:0] part
);
  localparam int GROUPS = WIDTH / GROUP_W;
  localparam int PART_W = $clog2(GROUP_W + 1);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [PART_W-1:0] cnt;
    always_comb begin
      cnt = '0;
      for (int b = 0; b < GROUP_W; b++)
        cnt = cnt + PART_W'(word[g*GROUP_W + b]);
    end
    always_ff @(posedge clk) begin
      if (!rst_n)  part[g] <= '0;
      else if (en) part[g] <= cnt;
    end
  end
endmodule

// File: rtl/nand_ecc_classify.sv
module nand_ecc_classify
  import nand_ecc_pkg::*;
#(
  parameter int GROUPS = 4,
  parameter int PART_W = 4,
  parameter int BYTE_W = 9
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           s1_valid,
  input  logic [WORD_W-1:0]              s1_syndrome,
  input  logic                           s1_blank,
  input  logic [GROUPS-1:0][PART_W-1:0]  part,
  output logic                           res_valid,
  output ecc_status_e                    res_status,
  output logic [BYTE_W-1:0]              res_byte,
  output logic [BIT_W-1:0]               res_bit
);
  localparam int SUM_W = $clog2(WORD_W + 1);

  logic [SUM_W-1:0] weight;
  ecc_status_e      status_nx;

  always_comb begin
    weight = '0;
    for (int g = 0; g < GROUPS; g++) weight = weight + SUM_W'(part[g]);
    if (weight == '0 || s1_blank)           status_nx = ST_CLEAN;
    else if (weight == SUM_W'(FIXABLE_WEIGHT)) status_nx = ST_FIXED;
    else if (weight == SUM_W'(1))          status_nx = ST_ECC_BAD;
    else                                   status_nx = ST_UNCORR;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_status <= ST_CLEAN;
      res_byte   <= '0;
      res_bit    <= '0;
    end else begin
      res_valid <= s1_valid;
      if (s1_valid) begin
        res_status <= status_nx;
        if (status_nx == ST_FIXED) begin
          res_byte <= s1_syndrome[16+BIT_W +: BYTE_W];
          res_bit  <= s1_syndrome[16 +: BIT_W];
        end else begin
          res_byte <= '0;
          res_bit  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/nand_ecc_fix.sv
module nand_ecc_fix
  import nand_ecc_pkg::*;
#(
  parameter int BYTE_W = 9
) (
  input  ecc_status_e       status,
  input  logic [BYTE_W-1:0] loc_byte,
  input  logic [BIT_W-1:0]  loc_bit,
  input  logic [BYTE_W-1:0] dat_addr,
  input  logic [7:0]        dat_in,
  output logic [7:0]        dat_out,
  output logic              hit
);
  logic [7:0] mask;
  always_comb begin
    hit     = (status == ST_FIXED) && (dat_addr == loc_byte);
    mask    = 8'(1) << loc_bit;
    dat_out = hit ? (dat_in ^ mask) : dat_in;
  end
endmodule

// File: rtl/nand_ecc_check.sv
module nand_ecc_check
  import nand_ecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 512,
  parameter int POP_GROUP   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [23:0] stored_ecc,
  input  logic [23:0] calc_ecc,
  output logic        res_valid,
  output logic [1:0]  res_status,
  output logic [8:0]  res_byte,
  output logic [2:0]  res_bit,
  input  logic [8:0]  dat_addr,
  input  logic [7:0]  dat_in,
  output logic [7:0]  dat_out
);
  localparam int BYTE_W = $clog2(CHUNK_BYTES);
  localparam int GROUPS = WORD_W / POP_GROUP;
  localparam int PART_W = $clog2(POP_GROUP + 1);

  // Named internal events, visible to the bound checker.
  logic [WORD_W-1:0]             syn_now;
  logic                          blank_now;
  logic                          s1_valid;
  logic [WORD_W-1:0]             s1_syndrome;
  logic                          s1_blank;
  logic [GROUPS-1:0][PART_W-1:0] s1_part;
  ecc_status_e                   st_q;
  logic                          fix_hit;

  nand_ecc_syndrome u_syn (
    .stored_ecc (stored_ecc),
    .calc_ecc   (calc_ecc),
    .syndrome   (syn_now),
    .blank_hit  (blank_now)
  );

  nand_ecc_popstage #(.WIDTH(WORD_W), .GROUP_W(POP_GROUP)) u_pop (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (in_valid),
    .word  (syn_now),
    .part  (s1_part)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid    <= 1'b0;
      s1_syndrome <= '0;
      s1_blank    <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_syndrome <= syn_now;
        s1_blank    <= blank_now;
      end
    end
  end

  nand_ecc_classify #(.GROUPS(GROUPS), .PART_W(PART_W), .BYTE_W(BYTE_W)) u_cls (
    .clk         (clk),
    .rst_n       (rst_n),
    .s1_valid    (s1_valid),
    .s1_syndrome (s1_syndrome),
    .s1_blank    (s1_blank),
    .part        (s1_part),
    .res_valid   (res_valid),
    .res_status  (st_q),
    .res_byte    (res_byte),
    .res_bit     (res_bit)
  );

  assign res_status = st_q;

  nand_ecc_fix #(.BYTE_W(BYTE_W)) u_fix (
    .status   (st_q),
    .loc_byte (res_byte),
    .loc_bit  (res_bit),
    .dat_addr (dat_addr),
    .dat_in   (dat_in),
    .dat_out  (dat_out),
    .hit      (fix_hit)
  );
endmodule

// File: rtl/nand_ecc_check_sva.sv
module nand_ecc_check_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       s1_valid,
  input logic       res_valid,
  input logic [1:0] res_status,
  input logic [8:0] res_byte,
  input logic [2:0] res_bit,
  input logic [8:0] dat_addr,
  input logic [7:0] dat_in,
  input logic [7:0] dat_out,
  input logic       fix_hit
);
  a_r2_stage_one: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);

  a_r2_stage_two: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> res_valid);

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !res_valid);

  a_r9_hold_status: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_status) && $stable(res_byte) && $stable(res_bit)));

  a_r8_location_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_status != 2'd1) |-> (res_byte == 9'd0 && res_bit == 3'd0));

  a_r10_at_most_one_flip: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dat_out ^ dat_in) <= 1);

  a_r10_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (res_status != 2'd1 || dat_addr != res_byte) |-> (dat_out == dat_in));

  a_r10_flip_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    fix_hit |-> ((dat_out ^ dat_in) == (8'd1 << res_bit)));
endmodule

bind nand_ecc_check nand_ecc_check_sva u_sva (.*);

// File: tb/tb_nand_ecc_check.sv
`timescale 1ns/1ps
module tb_nand_ecc_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [23:0] stored_ecc = '0;
  logic [23:0] calc_ecc = '0;
  logic        res_valid;
  logic [1:0]  res_status;
  logic [8:0]  res_byte;
  logic [2:0]  res_bit;
  logic [8:0]  dat_addr = '0;
  logic [7:0]  dat_in = '0;
  logic [7:0]  dat_out;

  int errors = 0;
  int checks = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #4 clk = ~clk;

  nand_ecc_check dut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rng(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // Bench view of the spreading: concatenation instead of field moves.
  function automatic logic [31:0] widen(input logic [23:0] c);
    return {4'h0, c[23:20], c[15:8], 4'h0, c[19:16], c[7:0]};
  endfunction

  function automatic logic [23:0] narrow(input logic [31:0] w);
    return {w[27:24], w[11:8], w[23:16], w[7:0]};
  endfunction

  function automatic int weight_of(input logic [31:0] w);
    int n = 0;
    logic [31:0] t = w;
    while (t != 0) begin
      t = t & (t - 1);
      n++;
    end
    return n;
  endfunction

  // Present one pair of codes and check the classification.
  task automatic run(input logic [23:0] st, input logic [23:0] ca, input bit latency_chk);
    logic [31:0] syn;
    int w, es, eb, ebit;
    syn = widen(st) ^ widen(ca);
    w = weight_of(syn);
    eb = 0; ebit = 0;
    if (st == 24'hFFFFFF && ca == 24'h0) es = 0;        // R7
    else if (w == 0)  es = 0;                          // R3
    else if (w == 12) begin es = 1; eb = int'(syn[27:19]); ebit = int'(syn[18:16]); end // R4
    else if (w == 1)  es = 2;                          // R5
    else              es = 3;                          // R6
    @(negedge clk);
    stored_ecc = st; calc_ecc = ca; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (latency_chk) check(res_valid == 1'b0, "R2 early valid", res_valid, 0);
    @(negedge clk);
    check(res_valid == 1'b1, "R2 valid due", res_valid, 1);
    check(res_status == 2'(es), "R3-class status", res_status, es);
    check(res_byte == 9'(eb), "R4/R8 byte", res_byte, eb);
    check(res_bit == 3'(ebit), "R4/R8 bit", res_bit, ebit);
    if (es == 1) begin
      dat_addr = 9'(eb); dat_in = 8'hA5; #1;
      check(dat_out == (8'hA5 ^ (8'd1 << ebit)), "R10 flip", dat_out, 8'hA5 ^ (8'd1 << ebit));
      dat_addr = 9'(eb) ^ 9'd1; #1;
      check(dat_out == 8'hA5, "R10 neighbour", dat_out, 8'hA5);
    end else begin
      dat_addr = 9'(eb); dat_in = 8'h3C; #1;
      check(dat_out == 8'h3C, "R5/R10 no change", dat_out, 8'h3C);
    end
    if (latency_chk) begin
      @(negedge clk);
      check(res_valid == 1'b0, "R2 pulse ends", res_valid, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(res_valid == 0, "R1 valid", res_valid, 0);
    check(res_status == 0, "R1 status", res_status, 0);
    check(res_byte == 0 && res_bit == 0, "R1 location", {res_byte, res_bit}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_status == 0 && res_valid == 0, "R1 after release", res_status, 0);

    // R2 latency, R3 clean on equal codes
    run(24'h123456, 24'h123456, 1'b1);
    for (int k = 0; k < 16; k++) begin
      rng = next_rng(rng);
      run(rng[23:0], rng[23:0], 1'b0);   // R3
    end

    // R4: every byte offset and bit index of a single data error
    for (int b = 0; b < 512; b++) begin
      for (int i = 0; i < 8; i++) begin
        logic [11:0] loc;
        logic [31:0] syn;
        loc = {9'(b), 3'(i)};
        syn = {4'h0, loc, 4'h0, ~loc};
        rng = next_rng(rng);
        run(rng[23:0] ^ narrow(syn), rng[23:0], 1'b0);
      end
    end

    // R5: each single-bit syndrome
    for (int p = 0; p < 24; p++) begin
      rng = next_rng(rng);
      run(rng[23:0] ^ (24'd1 << p), rng[23:0], 1'b0);
    end

    // R6: two-bit and mixed-weight syndromes
    for (int p = 1; p < 24; p++) run(24'h000001 | (24'd1 << p), 24'h0, 1'b0);
    for (int k = 0; k < 200; k++) begin
      logic [31:0] a;
      rng = next_rng(rng); a = rng;
      rng = next_rng(rng);
      run(a[23:0], rng[23:0], 1'b0);
    end

    // R7: erased chunk, and its near misses
    run(24'hFFFFFF, 24'h000000, 1'b1);
    run(24'hFFFFFF, 24'h000001, 1'b0);
    run(24'hFFFFFE, 24'h000000, 1'b0);

    // R9 and R10: hold after a fixable result, codes change without strobe
    run(narrow({4'h0, 12'h2AB, 4'h0, ~12'h2AB}), 24'h0, 1'b0);
    @(negedge clk);
    stored_ecc = 24'h000001; calc_ecc = 24'h0;
    repeat (4) @(negedge clk);
    check(res_status == 2'd1, "R9 status held", res_status, 1);
    check(res_byte == 9'h055 && res_bit == 3'd3, "R9 location held", {res_byte, res_bit}, {9'h055, 3'd3});
    for (int a = 0; a < 512; a++) begin
      logic [7:0] e;
      dat_addr = 9'(a); dat_in = 8'(a * 7); #1;
      e = (a == 9'h055) ? (8'(a * 7) ^ 8'h08) : 8'(a * 7);
      check(dat_out == e, "R10 sweep", dat_out, e);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule